// File: doc/BRIEF.md
# Write Protection Command Sequencer

This block stands between the write port of a byte-wide non-volatile memory and its storage array. It watches every write strobe, with its address and data byte, and decides whether that write may reach the array. Protection starts out off, and in that state every write passes through. Three key writes (AA to 5555, then 55 to 2AAA, then A0 to 5555) turn protection on and open one page-load window. Every write inside the window is stored. The page engine signals the end of the window with a one-cycle pulse. After that pulse the array is protected again, and any write that does not follow a fresh unlock is discarded.

A six-write sequence turns protection off: AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555. The first two writes are shared with the unlock sequence, and the third key byte selects the branch. While protection is on, key writes are masked from storage. The protection flag has no reset, so it survives the block reset in the same way that a non-volatile bit survives a power cycle. A write whose address or data does not match the next expected step returns the tracker to its start.

Top module: `wp_cmd_seq`

## Requirements
- R1: After power-up, `prot_on` is 0, and `arr_wr_en` and `cmd_mask` are 0 while `wr_stb` is low.
- R2: While `prot_on` is 0, every strobed write has `arr_wr_en`=1 in the cycle of the strobe. This includes key writes, which have `cmd_mask`=0.
- R3: The writes AA@5555, 55@2AAA and A0@5555 on consecutive strobes set `prot_on` from the next cycle and open a load window. Every write strobed while the window is open has `arr_wr_en`=1.
- R4: A `load_done` pulse closes the window. After it, with `prot_on`=1, a write that does not follow a new unlock has `arr_wr_en`=0, and `prot_on` stays 1.
- R5: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA and 20@5555 clear `prot_on` from the cycle after the sixth write. The next ordinary write is then stored.
- R6: While `prot_on`=1 and no window is open, a write that matches the next key step has `cmd_mask`=1 and `arr_wr_en`=0. `cmd_mask` is never 1 while `prot_on`=0.
- R7: A write with the wrong address or the wrong data for the next step sends the tracker back to its first step. Finishing the remaining steps after such a write neither unlocks nor disables.
- R8: Only address bits 14:0 are compared. Bit 15 of `wr_addr` has no effect, so D555 and AAAA act as 5555 and 2AAA.
- R9: `arr_wr_en` and `cmd_mask` are 1 only in a cycle with `wr_stb`=1, and never both at once.
- R10: Writes inside an open load window are data, not keys. AA@5555 in the window is stored with `cmd_mask`=0.
- R11: `rst_n` clears a partial key sequence and an open window but leaves `prot_on` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the sequence tracker and the window; the protection flag is kept |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | 16 | Write address; bits 14:0 are compared |
| wr_data | input | 8 | Write data byte |
| load_done | input | 1 | Pulse from the page engine: the load window has closed |
| arr_wr_en | output | 1 | Allows this write into the array (combinational with the strobe) |
| cmd_mask | output | 1 | This write is a key byte and is kept out of the array |
| prot_on | output | 1 | Protected mode flag |

## Verification
The bench sweeps all 256 data values at the first key address while the array is protected. Only AA may be masked; a decoder that compares too loosely would mask or store other bytes. It also breaks the disable sequence at each of its six positions in turn and completes the remaining steps. A tracker that skipped a wrong step instead of restarting would drop protection there. The remaining checks cover key bytes inside an open window, which a design that tracks keys everywhere would mask. They also cover reset in the middle of a sequence, which a design holding partial state would let unlock, and an address with bit 15 set, which a full-width compare would reject.

// File: rtl/wpseq_pkg.sv
package wpseq_pkg;
    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;
    localparam logic [DATA_W-1:0] KEY_OPEN   = 8'hA0;
    localparam logic [DATA_W-1:0] KEY_ERASE  = 8'h80;
    localparam logic [DATA_W-1:0] KEY_CLEAR  = 8'h20;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_K1,
        SQ_K2,
        SQ_D3,
        SQ_D4,
        SQ_D5
    } seq_e;

    typedef struct packed {
        seq_e seq;
        logic win;
    } seq_st_t;
endpackage

// File: rtl/wp_cmd_decode.sv
module wp_cmd_decode
    import wpseq_pkg::*;
#(
    parameter int CMP_W = 15,
    parameter logic [CMP_W-1:0] ADDR_A = 15'h5555,
    parameter logic [CMP_W-1:0] ADDR_B = 15'h2AAA
) (
    input  seq_e              cur,
    input  logic [CMP_W-1:0]  addr,
    input  logic [DATA_W-1:0] data,
    output logic              hit,
    output logic              unlock,
    output logic              disarm,
    output seq_e              nxt
);
    logic [CMP_W-1:0]  want_a;
    logic [DATA_W-1:0] want_d;
    logic              branch;

    always_comb begin
        want_a = ADDR_A;
        want_d = KEY_FIRST;
        case (cur)
            SQ_K1:   begin want_a = ADDR_B; want_d = KEY_SECOND; end
            SQ_K2:   begin want_a = ADDR_A; want_d = KEY_OPEN;   end
            SQ_D3:   begin want_a = ADDR_A; want_d = KEY_FIRST;  end
            SQ_D4:   begin want_a = ADDR_B; want_d = KEY_SECOND; end
            SQ_D5:   begin want_a = ADDR_A; want_d = KEY_CLEAR;  end
            default: begin want_a = ADDR_A; want_d = KEY_FIRST;  end
        endcase
        branch = (cur == SQ_K2) && (data == KEY_ERASE);
        hit    = (addr == want_a) && ((data == want_d) || branch);
        unlock = hit && (cur == SQ_K2) && !branch;
        disarm = hit && (cur == SQ_D5);
        nxt    = SQ_IDLE;
        if (hit) begin
            case (cur)
                SQ_IDLE: nxt = SQ_K1;
                SQ_K1:   nxt = SQ_K2;
                SQ_K2:   nxt = branch ? SQ_D3 : SQ_IDLE;
                SQ_D3:   nxt = SQ_D4;
                SQ_D4:   nxt = SQ_D5;
                default: nxt = SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wp_write_gate.sv
module wp_write_gate (
    input  logic stb,
    input  logic key_hit,
    input  logic prot,
    input  logic win,
    output logic store_en,
    output logic key_mask
);
    always_comb begin
        key_mask = key_hit && prot;
        store_en = stb && !key_mask && (!prot || win);
    end
endmodule

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq
    import wpseq_pkg::*;
#(
    parameter int BUS_AW = 16,
    parameter int CMP_W  = 15,
    parameter logic [CMP_W-1:0] ADDR_A = 15'h5555,
    parameter logic [CMP_W-1:0] ADDR_B = 15'h2AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BUS_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              load_done,
    output logic              arr_wr_en,
    output logic              cmd_mask,
    output logic              prot_on
);
    seq_st_t st_d, st_q;
    logic    prot_d;
    logic    prot_q = 1'b0;
    logic    win_q;

    logic [CMP_W-1:0] cmp_addr;
    logic hit, unlock, disarm, live, hit_v;
    seq_e nxt;

    assign cmp_addr = wr_addr[CMP_W-1:0];

    generate
        if (BUS_AW > CMP_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^wr_addr[BUS_AW-1:CMP_W];
        end
    endgenerate

    wp_cmd_decode #(.CMP_W(CMP_W), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)) u_dec (
        .cur    (st_q.seq),
        .addr   (cmp_addr),
        .data   (wr_data),
        .hit    (hit),
        .unlock (unlock),
        .disarm (disarm),
        .nxt    (nxt)
    );

    assign live  = wr_stb && !st_q.win;
    assign hit_v = live && hit;

    always_comb begin
        st_d   = st_q;
        prot_d = prot_q;
        if (live)
            st_d.seq = nxt;
        if (st_q.win && load_done)
            st_d.win = 1'b0;
        if (hit_v && unlock) begin
            st_d.win = 1'b1;
            prot_d   = 1'b1;
        end
        if (hit_v && disarm)
            prot_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.seq <= SQ_IDLE;
            st_q.win <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        prot_q <= prot_d;
    end

    assign win_q   = st_q.win;
    assign prot_on = prot_q;

    wp_write_gate u_gate (
        .stb      (wr_stb),
        .key_hit  (hit_v),
        .prot     (prot_q),
        .win      (st_q.win),
        .store_en (arr_wr_en),
        .key_mask (cmd_mask)
    );
endmodule

// File: rtl/wp_cmd_seq_chk.sv
module wp_cmd_seq_chk
    import wpseq_pkg::*;
#(
    parameter int BUS_AW = 16,
    parameter int CMP_W  = 15,
    parameter logic [CMP_W-1:0] ADDR_A = 15'h5555
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [BUS_AW-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              load_done,
    input logic              arr_wr_en,
    input logic              cmd_mask,
    input logic              prot_on,
    input logic              win_q
);
    assert_en_needs_stb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> wr_stb);

    assert_no_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_wr_en && cmd_mask));

    assert_mask_only_prot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_mask |-> prot_on);

    assert_rise_by_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> $past(wr_stb && wr_data == KEY_OPEN
                                 && wr_addr[CMP_W-1:0] == ADDR_A));

    assert_fall_by_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> $past(wr_stb && wr_data == KEY_CLEAR
                                 && wr_addr[CMP_W-1:0] == ADDR_A));

    assert_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_on && !win_q && wr_stb) |-> !arr_wr_en);

    assert_win_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_done && win_q) |-> !win_q);
endmodule

bind wp_cmd_seq wp_cmd_seq_chk #(.BUS_AW(BUS_AW), .CMP_W(CMP_W), .ADDR_A(ADDR_A)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .load_done (load_done),
    .arr_wr_en (arr_wr_en),
    .cmd_mask  (cmd_mask),
    .prot_on   (prot_on),
    .win_q     (win_q)
);

// File: tb/sim_wp_cmd_seq.sv
`timescale 1ns/1ps
module sim_wp_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        load_done = 1'b0;
    logic        arr_wr_en, cmd_mask, prot_on;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    wp_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .load_done(load_done), .arr_wr_en(arr_wr_en),
        .cmd_mask(cmd_mask), .prot_on(prot_on)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d,
                      input logic en, input logic mk, input string tag);
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        #1;
        chk({tag, " en"}, {7'd0, arr_wr_en}, {7'd0, en});
        chk({tag, " mask"}, {7'd0, cmd_mask}, {7'd0, mk});
        @(negedge clk);
        wr_stb = 1'b0;
        #1;
        chk("R9 idle outputs", {6'd0, arr_wr_en, cmd_mask}, 8'd0);
    endtask

    task automatic pulse_done();
        @(negedge clk); load_done = 1'b1;
        @(negedge clk); load_done = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        #1;
        chk("R1 prot after power-up", {7'd0, prot_on}, 8'd0);
        chk("R1 outputs idle", {6'd0, arr_wr_en, cmd_mask}, 8'd0);
        rst_n = 1'b1;

        // R2: unprotected pass-through, key bytes stored too
        wr(16'h1234, 8'h5A, 1'b1, 1'b0, "R2 plain");
        wr(16'h5555, 8'hAA, 1'b1, 1'b0, "R2 key unprotected");
        wr(16'h2AAA, 8'h55, 1'b1, 1'b0, "R2 key2 unprotected");
        wr(16'h5555, 8'hA0, 1'b1, 1'b0, "R3 open unprotected");
        #1 chk("R3 prot set by unlock", {7'd0, prot_on}, 8'd1);
        wr(16'h0100, 8'h11, 1'b1, 1'b0, "R3 window data");
        wr(16'h5555, 8'hAA, 1'b1, 1'b0, "R10 key in window");
        wr(16'h2AAA, 8'h55, 1'b1, 1'b0, "R10 key2 in window");
        pulse_done();
        wr(16'h0100, 8'h22, 1'b0, 1'b0, "R4 after window");
        #1 chk("R4 prot stays", {7'd0, prot_on}, 8'd1);

        do_reset();
        #1 chk("R11 prot kept over reset", {7'd0, prot_on}, 8'd1);

        // R6: sweep all data bytes at the first key address
        for (int d = 0; d < 256; d++)
            wr(16'h5555, d[7:0], 1'b0, (d == 8'hAA), "R6 sweep");

        // R3/R6: protected unlock
        wr(16'h5555, 8'hAA, 1'b0, 1'b1, "R6 key1");
        wr(16'h2AAA, 8'h55, 1'b0, 1'b1, "R6 key2");
        wr(16'h5555, 8'hA0, 1'b0, 1'b1, "R6 key3");
        wr(16'h0200, 8'h33, 1'b1, 1'b0, "R3 protected window");
        wr(16'h0201, 8'h34, 1'b1, 1'b0, "R3 protected window 2");
        pulse_done();
        wr(16'h0200, 8'h35, 1'b0, 1'b0, "R4 rearmed");

        // R7: wrong data, then wrong address
        wr(16'h5555, 8'hAA, 1'b0, 1'b1, "R7 k1");
        wr(16'h2AAA, 8'h55, 1'b0, 1'b1, "R7 k2");
        wr(16'h5555, 8'h33, 1'b0, 1'b0, "R7 bad data");
        wr(16'h5555, 8'hA0, 1'b0, 1'b0, "R7 late open");
        wr(16'h0300, 8'h44, 1'b0, 1'b0, "R7 no window");
        wr(16'h5555, 8'hAA, 1'b0, 1'b1, "R7 k1b");
        wr(16'h2AAB, 8'h55, 1'b0, 1'b0, "R7 bad addr");
        wr(16'h5555, 8'hA0, 1'b0, 1'b0, "R7 late open b");
        wr(16'h0300, 8'h45, 1'b0, 1'b0, "R7 no window b");

        // R7: break the disable sequence at every position
        for (int k = 0; k < 6; k++) begin
            logic [15:0] sa [6];
            logic [7:0]  sd [6];
            sa = '{16'h5555, 16'h2AAA, 16'h5555, 16'h5555, 16'h2AAA, 16'h5555};
            sd = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h20};
            for (int s = 0; s < 6; s++) begin
                @(negedge clk);
                wr_stb = 1'b1; wr_addr = sa[s];
                wr_data = (s == k) ? (sd[s] ^ 8'h01) : sd[s];
                @(negedge clk);
                wr_stb = 1'b0;
            end
            #1 chk("R7 broken disable keeps prot", {7'd0, prot_on}, 8'd1);
        end

        // R8: bit 15 ignored
        wr(16'hD555, 8'hAA, 1'b0, 1'b1, "R8 k1 hi");
        wr(16'hAAAA, 8'h55, 1'b0, 1'b1, "R8 k2 hi");
        wr(16'hD555, 8'hA0, 1'b0, 1'b1, "R8 k3 hi");
        wr(16'h0400, 8'h55, 1'b1, 1'b0, "R8 window");
        pulse_done();

        // R11: reset drops a partial sequence
        wr(16'h5555, 8'hAA, 1'b0, 1'b1, "R11 k1");
        wr(16'h2AAA, 8'h55, 1'b0, 1'b1, "R11 k2");
        do_reset();
        wr(16'h5555, 8'hA0, 1'b0, 1'b0, "R11 open after reset");
        wr(16'h0500, 8'h66, 1'b0, 1'b0, "R11 still locked");

        // R5: disable
        wr(16'h5555, 8'hAA, 1'b0, 1'b1, "R5 s1");
        wr(16'h2AAA, 8'h55, 1'b0, 1'b1, "R5 s2");
        wr(16'h5555, 8'h80, 1'b0, 1'b1, "R5 s3");
        wr(16'h5555, 8'hAA, 1'b0, 1'b1, "R5 s4");
        wr(16'h2AAA, 8'h55, 1'b0, 1'b1, "R5 s5");
        wr(16'h5555, 8'h20, 1'b0, 1'b1, "R5 s6");
        #1 chk("R5 prot cleared", {7'd0, prot_on}, 8'd0);
        wr(16'h0600, 8'h77, 1'b1, 1'b0, "R5 write after disable");
        wr(16'h5555, 8'hAA, 1'b1, 1'b0, "R6 no mask unprotected");

        finish_run();
    end
endmodule